// File: doc/BRIEF.md
# Selectable Window / Timeout Watchdog

This block watches a service input from a host processor and raises an active-low fault when that service comes at the wrong time. Time is counted in ticks of a slow oscillator, delivered as a one-cycle `tick` strobe on the system clock. Two modes are available. In window mode every period splits into a closed part, where service is forbidden, and an open part, where service is required. In timeout mode only the open part exists, and service may arrive at any point before it expires.

The watchdog runs only while power-good is high and the active-low enable is low. It starts in an initialization window eight times the base period. A fault drives `fault_n` low for a fixed number of ticks and then restarts the watchdog. A flag from the oscillator monitor holds `fault_n` low for as long as it is set while the watchdog is enabled. When power-good is low, `fault_hiz` tells the pad to float the fault pin.

Top module: `wdt_guard`

## Requirements
- R1: While `pgood` is low, `fault_hiz` is 1 and `fault_n` is 1. While `en_n` is high, `fault_n` stays 1 no matter how long ticks run and whatever the service input does.
- R2: After initialization, the first open window lasts 8 × P ticks, where P is the base period. If no qualified service arrives, `fault_n` goes low on tick 8 × P of that window and not before.
- R3: With `long_sel` = 1, P is 5 × `BASE_TICKS`. With `long_sel` = 0, P is `BASE_TICKS`.
- R4: With `ratio_sel` = 0 the closed and open windows each last P/2 ticks. With `ratio_sel` = 1 the closed window lasts P/9 ticks and the open window lasts 8P/9 ticks.
- R5: In window mode (`mode_std` = 0), a qualified service during a closed window drives `fault_n` low on the tick where it qualifies.
- R6: In window mode, a qualified service in the initialization or open window (including its last tick) starts a closed window. An open window that ends without service raises a fault on its last tick.
- R7: In timeout mode (`mode_std` = 1) there is no closed window. A qualified service restarts a full P-tick open window, and a P-tick window with no service raises a fault.
- R8: A service counts only once `svc_in` has been high for `MIN_SVC_TICKS` consecutive ticks. It counts on the tick that reaches that count. A shorter high pulse has no effect, and one long pulse counts once.
- R9: A fault holds `fault_n` low for exactly `HOLD_TICKS` ticks. The watchdog then enters a new initialization window.
- R10: While the watchdog is enabled, `osc_bad` = 1 holds `fault_n` low. Clearing `osc_bad` starts a fresh initialization window. While the watchdog is disabled, `osc_bad` has no effect.
- R11: A rising `pgood` while `en_n` is low, or a falling `en_n` while `pgood` is high, restarts the watchdog in a full initialization window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per oscillator tick |
| mode_std | input | 1 | 0 = window mode, 1 = timeout-only mode |
| long_sel | input | 1 | 1 = base period five times longer |
| ratio_sel | input | 1 | 0 = open:closed 1:1, 1 = open:closed 8:1 |
| svc_in | input | 1 | Service input from the host |
| en_n | input | 1 | Active-low watchdog enable |
| pgood | input | 1 | Supply power-good |
| osc_bad | input | 1 | Oscillator set-resistor fault flag |
| fault_n | output | 1 | Active-low fault output |
| fault_hiz | output | 1 | 1 = fault pad should float |

## Verification
The bench targets the edges of each window. Service landing on the last tick of an open window must be accepted; a design that checks expiry before service would fault there. Checks fall on ticks 8P−1 and 8P of the initialization window, and on the last tick of the open window for both ratios and both period scales, so an off-by-one or a wrong divisor shows up as a fault one tick early or late. Service that is one tick too short, or that arrives right after a previous service in timeout mode, must not fault. A design that qualifies on edges alone, or that keeps a closed window in timeout mode, faults there instead. The bench also drops power-good, toggles the enable and sets the oscillator flag in the middle of a window, and requires a full new initialization window afterwards. A design that keeps its old count would fault too early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        WD_OFF    = 3'd0,
        WD_INIT   = 3'd1,
        WD_OPEN   = 3'd2,
        WD_CLOSED = 3'd3,
        WD_HOLD   = 3'd4
    } wdt_state_e;

    typedef struct packed {
        logic std_mode;
        logic long_per;
        logic ratio_hi;
    } wdt_cfg_t;

    localparam int unsigned LONG_SCALE = 5;
    localparam int unsigned INIT_SCALE = 8;

    function automatic int unsigned period_len(input int unsigned base, input logic long_per);
        return long_per ? base * LONG_SCALE : base;
    endfunction

    function automatic int unsigned init_len(input int unsigned base, input logic long_per);
        return INIT_SCALE * period_len(base, long_per);
    endfunction

    function automatic int unsigned closed_len(input int unsigned base, input wdt_cfg_t cfg);
        int unsigned p;
        p = period_len(base, cfg.long_per);
        return cfg.ratio_hi ? p / 9 : p / 2;
    endfunction

    function automatic int unsigned open_len(input int unsigned base, input wdt_cfg_t cfg);
        int unsigned p;
        p = period_len(base, cfg.long_per);
        if (cfg.std_mode)
            return p;
        return cfg.ratio_hi ? (p / 9) * 8 : p / 2;
    endfunction

endpackage

// File: rtl/wdt_svc_filter.sv
module wdt_svc_filter #(
    parameter int unsigned MIN_SVC_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic svc_in,
    output logic svc_evt
);
    localparam int unsigned CW = $clog2(MIN_SVC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_SVC_TICKS - 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_SVC_TICKS);

    logic [CW-1:0] high_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !svc_in)
            high_cnt_q <= '0;
        else if (tick && high_cnt_q < FULL)
            high_cnt_q <= high_cnt_q + 1'b1;
    end

    assign svc_evt = tick && svc_in && (high_cnt_q == LAST);

endmodule

// File: rtl/wdt_window_fsm.sv
module wdt_window_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 72,
    parameter int unsigned HOLD_TICKS = 16,
    parameter int unsigned TW         = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  wdt_cfg_t   cfg,
    input  logic       svc_evt,
    output wdt_state_e st
);
    wdt_state_e    st_q, st_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [TW-1:0] lim;
    logic          expire;

    always_comb begin
        unique case (st_q)
            WD_INIT:   lim = TW'(init_len(BASE_TICKS, cfg.long_per));
            WD_OPEN:   lim = TW'(open_len(BASE_TICKS, cfg));
            WD_CLOSED: lim = TW'(closed_len(BASE_TICKS, cfg));
            WD_HOLD:   lim = TW'(HOLD_TICKS);
            default:   lim = TW'(1);
        endcase
    end

    assign expire = (tmr_q == lim - 1'b1);

    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        if (!run) begin
            st_d  = WD_OFF;
            tmr_d = '0;
        end else begin
            unique case (st_q)
                WD_OFF: begin
                    st_d  = WD_INIT;
                    tmr_d = '0;
                end
                WD_INIT, WD_OPEN: begin
                    if (tick) begin
                        if (svc_evt) begin
                            st_d  = cfg.std_mode ? WD_OPEN : WD_CLOSED;
                            tmr_d = '0;
                        end else if (expire) begin
                            st_d  = WD_HOLD;
                            tmr_d = '0;
                        end else begin
                            tmr_d = tmr_q + 1'b1;
                        end
                    end
                end
                WD_CLOSED: begin
                    if (tick) begin
                        if (svc_evt) begin
                            st_d  = WD_HOLD;
                            tmr_d = '0;
                        end else if (expire) begin
                            st_d  = WD_OPEN;
                            tmr_d = '0;
                        end else begin
                            tmr_d = tmr_q + 1'b1;
                        end
                    end
                end
                WD_HOLD: begin
                    if (tick) begin
                        if (expire) begin
                            st_d  = WD_INIT;
                            tmr_d = '0;
                        end else begin
                            tmr_d = tmr_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d  = WD_OFF;
                    tmr_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WD_OFF;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/wdt_fault_drv.sv
module wdt_fault_drv
    import wdt_pkg::*;
(
    input  logic       pgood,
    input  logic       en_n,
    input  logic       osc_bad,
    input  wdt_state_e st,
    output logic       fault_n,
    output logic       fault_hiz
);
    logic active;

    assign active    = pgood && !en_n;
    assign fault_n   = !active || (!osc_bad && st != WD_HOLD);
    assign fault_hiz = !pgood;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_TICKS    = 72,
    parameter int unsigned HOLD_TICKS    = 16,
    parameter int unsigned MIN_SVC_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mode_std,
    input  logic long_sel,
    input  logic ratio_sel,
    input  logic svc_in,
    input  logic en_n,
    input  logic pgood,
    input  logic osc_bad,
    output logic fault_n,
    output logic fault_hiz
);
    localparam int unsigned MAX_WIN = INIT_SCALE * LONG_SCALE * BASE_TICKS;
    localparam int unsigned MAX_LEN = (MAX_WIN > HOLD_TICKS) ? MAX_WIN : HOLD_TICKS;
    localparam int unsigned TW      = $clog2(MAX_LEN + 1);

    wdt_cfg_t   cfg;
    wdt_state_e st_w;
    logic       svc_evt;
    logic       run;

    assign cfg = '{std_mode: mode_std, long_per: long_sel, ratio_hi: ratio_sel};
    assign run = pgood && !en_n && !osc_bad;

    wdt_svc_filter #(
        .MIN_SVC_TICKS(MIN_SVC_TICKS)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .svc_in  (svc_in),
        .svc_evt (svc_evt)
    );

    wdt_window_fsm #(
        .BASE_TICKS (BASE_TICKS),
        .HOLD_TICKS (HOLD_TICKS),
        .TW         (TW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (run),
        .cfg     (cfg),
        .svc_evt (svc_evt),
        .st      (st_w)
    );

    wdt_fault_drv u_drv (
        .pgood     (pgood),
        .en_n      (en_n),
        .osc_bad   (osc_bad),
        .st        (st_w),
        .fault_n   (fault_n),
        .fault_hiz (fault_hiz)
    );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       mode_std,
    input logic       en_n,
    input logic       pgood,
    input logic       osc_bad,
    input logic       fault_n,
    input logic       fault_hiz,
    input wdt_state_e st
);
    AST_FLOAT_NO_PGOOD: assert property (@(posedge clk) disable iff (rst)
        !pgood |-> (fault_hiz && fault_n)); // R1

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        en_n |-> fault_n); // R1

    AST_IDLE_GOES_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pgood || en_n || osc_bad) |=> (st == WD_OFF)); // R10

    AST_OSC_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
        (pgood && !en_n && osc_bad) |-> !fault_n); // R10

    AST_WAKE_TO_INIT: assert property (@(posedge clk) disable iff (rst)
        (pgood && !en_n && !osc_bad && st == WD_OFF) |=> (st == WD_INIT)); // R11

    AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(st == WD_INIT) |-> ($past(st) == WD_OFF || $past(st) == WD_HOLD)); // R9

    AST_CLOSED_WINDOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(st == WD_CLOSED) |->
            (!$past(mode_std) && ($past(st) == WD_INIT || $past(st) == WD_OPEN))); // R6

    AST_HOLD_FROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(st == WD_HOLD) |->
            ($past(st) == WD_INIT || $past(st) == WD_OPEN || $past(st) == WD_CLOSED)); // R9

endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_std  (mode_std),
    .en_n      (en_n),
    .pgood     (pgood),
    .osc_bad   (osc_bad),
    .fault_n   (fault_n),
    .fault_hiz (fault_hiz),
    .st        (st_w)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
    localparam int BASE  = 18;
    localparam int HOLD  = 4;
    localparam int MINW  = 3;
    localparam int P_S   = BASE;
    localparam int P_L   = 5 * BASE;
    localparam int INI_S = 8 * P_S;
    localparam int INI_L = 8 * P_L;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic mode_std = 1'b0;
    logic long_sel = 1'b0;
    logic ratio_sel = 1'b0;
    logic svc_in = 1'b0;
    logic en_n = 1'b1;
    logic pgood = 1'b0;
    logic osc_bad = 1'b0;
    logic fault_n;
    logic fault_hiz;

    int n_chk = 0;
    int n_bad = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    wdt_guard #(
        .BASE_TICKS    (BASE),
        .HOLD_TICKS    (HOLD),
        .MIN_SVC_TICKS (MINW)
    ) i_wdt_guard (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode_std  (mode_std),
        .long_sel  (long_sel),
        .ratio_sel (ratio_sel),
        .svc_in    (svc_in),
        .en_n      (en_n),
        .pgood     (pgood),
        .osc_bad   (osc_bad),
        .fault_n   (fault_n),
        .fault_hiz (fault_hiz)
    );

    task automatic check(input string req, input string sig, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, sig, act, exp, $time);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int n);
        svc_in = 1'b1;
        ticks(n);
        svc_in = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                settle();
                check("R1", "fault_hiz", fault_hiz, 1'b1);
                check("R1", "fault_n", fault_n, 1'b1);

                // R11/R2: power up with enable low, then miss the init window
                pgood = 1'b1;
                en_n  = 1'b0;
                settle();
                check("R1", "fault_hiz", fault_hiz, 1'b0);
                ticks(INI_S - 1);
                check("R2", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R2", "fault_n", fault_n, 1'b0);
                ticks(HOLD - 1);
                check("R9", "fault_n", fault_n, 1'b0);
                ticks(1);
                check("R9", "fault_n", fault_n, 1'b1);

                // R6/R8/R4/R5: window mode, 1:1 ratio
                ticks(5);
                pulse(MINW);
                check("R6", "fault_n", fault_n, 1'b1);
                pulse(MINW - 1);
                ticks(1);
                check("R8", "fault_n", fault_n, 1'b1);
                ticks(P_S / 2 - MINW - 1);
                check("R4", "fault_n", fault_n, 1'b1);
                ticks(1);
                ticks(P_S / 2 - MINW);
                pulse(MINW);
                check("R6", "fault_n", fault_n, 1'b1);
                ticks(2);
                svc_in = 1'b1;
                ticks(MINW - 1);
                check("R8", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R5", "fault_n", fault_n, 1'b0);
                svc_in = 1'b0;
                ticks(HOLD);
                check("R9", "fault_n", fault_n, 1'b1);

                // R4/R6: 1:1 open window timeout
                pulse(MINW);
                ticks(P_S / 2);
                ticks(P_S / 2 - 1);
                check("R4", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R6", "fault_n", fault_n, 1'b0);
                ticks(HOLD);

                // R4: 8:1 ratio
                ratio_sel = 1'b1;
                pulse(MINW);
                ticks(P_S / 9);
                ticks(8 * P_S / 9 - 1);
                check("R4", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R4", "fault_n", fault_n, 1'b0);
                ticks(HOLD);
                ratio_sel = 1'b0;

                // R7: timeout mode
                mode_std = 1'b1;
                pulse(MINW);
                ticks(1);
                pulse(MINW);
                check("R7", "fault_n", fault_n, 1'b1);
                ticks(P_S - 1);
                check("R7", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R7", "fault_n", fault_n, 1'b0);
                ticks(HOLD);

                // R3: long period in timeout mode, then long init window
                long_sel = 1'b1;
                pulse(MINW);
                ticks(P_L - 1);
                check("R3", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R3", "fault_n", fault_n, 1'b0);
                ticks(HOLD);
                mode_std = 1'b0;
                ticks(INI_L - 1);
                check("R3", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R3", "fault_n", fault_n, 1'b0);
                ticks(HOLD);
                long_sel = 1'b0;

                // R10: oscillator fault while enabled
                ticks(10);
                osc_bad = 1'b1;
                settle();
                check("R10", "fault_n", fault_n, 1'b0);
                ticks(50);
                check("R10", "fault_n", fault_n, 1'b0);
                osc_bad = 1'b0;
                settle();
                check("R10", "fault_n", fault_n, 1'b1);
                ticks(INI_S - 1);
                check("R10", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R10", "fault_n", fault_n, 1'b0);
                ticks(HOLD);

                // R1/R10: disabled watchdog stays quiet
                en_n = 1'b1;
                settle();
                check("R1", "fault_n", fault_n, 1'b1);
                pulse(MINW);
                ticks(INI_S + 10);
                check("R1", "fault_n", fault_n, 1'b1);
                osc_bad = 1'b1;
                settle();
                check("R10", "fault_n", fault_n, 1'b1);
                osc_bad = 1'b0;
                pgood = 1'b0;
                settle();
                check("R1", "fault_hiz", fault_hiz, 1'b1);
                check("R1", "fault_n", fault_n, 1'b1);

                // R11: enable falling edge, then power-good bounce
                pgood = 1'b1;
                settle();
                en_n = 1'b0;
                settle();
                ticks(100);
                pgood = 1'b0;
                settle();
                pgood = 1'b1;
                settle();
                ticks(INI_S - 1);
                check("R11", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R11", "fault_n", fault_n, 1'b0);
                ticks(HOLD);
                ticks(100);
                en_n = 1'b1;
                settle();
                en_n = 1'b0;
                settle();
                ticks(INI_S - 1);
                check("R11", "fault_n", fault_n, 1'b1);
                ticks(1);
                check("R11", "fault_n", fault_n, 1'b0);
            end
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule